// File: doc/BRIEF.md
# Circuit-Switched Path Setup Interface

This block is the per-node network interface that runs a circuit-switched photonic link, one circuit at a time in each direction. As a sender, it takes a host request with a destination, puts a path setup packet on the control port and then waits. A one-bit optical acknowledgment means the path is reserved: the block streams one 2 KiB message as 512 words of 32 bits, raises a one-cycle teardown pulse so the path is released, and tells the host it is done. If a path-blocked packet comes back, the block sends nothing, waits a pseudo-random backoff and issues the setup again.

As a receiver, the block answers a setup packet that arrives while it is free with a single-cycle acknowledgment pulse. It then forwards arriving data words to the host until the upstream teardown closes the circuit.

The sender states are IDLE, SETUP_SENT, WAIT_ACK, TRANSMIT, TEARDOWN and BACKOFF:
- IDLE→SETUP_SENT on a host request.
- SETUP_SENT→WAIT_ACK unconditionally.
- WAIT_ACK→BACKOFF on path-blocked, and WAIT_ACK→TRANSMIT on acknowledgment.
- TRANSMIT→TEARDOWN after the last word.
- TEARDOWN→IDLE unconditionally.
- BACKOFF→SETUP_SENT when the backoff count expires.

The receiver states are IDLE and RECEIVE:
- IDLE→RECEIVE on an arriving setup packet.
- RECEIVE→IDLE on teardown.

Top module: `path_setup_ni`

## Requirements
- R1: While reset is held, setup_valid, data_valid, teardown_out, host_done, ack_out and rx_out_valid are all 0.
- R2: A host_req seen in IDLE makes setup_valid high for exactly one cycle in the next cycle, with setup_dest equal to the host_dest that was sampled.
- R3: data_valid stays 0 until ack_in is seen in WAIT_ACK. It rises in the cycle after that acknowledgment.
- R4: One message is exactly 512 consecutive cycles of data_valid, with data_idx running from 0 to 511 in steps of one.
- R5: teardown_out pulses for one cycle right after the word with index 511. host_done pulses for one cycle in the cycle after teardown_out, and the block is then idle.
- R6: If blocked_in is seen in WAIT_ACK, no data is sent. The block stays quiet for 8 + (L mod 16) cycles and then raises setup_valid again. L is the value of a 16-bit right-shift Galois LFSR (feedback mask 0xB400, reset value 0xACE1) taken in the cycle blocked_in is sampled. The LFSR steps on every clock after reset.
- R7: An ack_in seen in any state other than WAIT_ACK has no effect.
- R8: If ack_in and blocked_in are seen together in WAIT_ACK, the block takes the blocked path.
- R9: A setup_in seen while the receiver is idle produces a single-cycle ack_out in the next cycle. A setup_in seen while it is receiving produces no ack_out.
- R10: While receiving, each rx_valid word appears on rx_out_data with rx_out_valid one cycle later. teardown_in returns the receiver to idle, and rx_valid outside a circuit is dropped.
- R11: host_req has no effect while the sender is not in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host asks to send one message |
| host_dest | input | 6 | Destination node of the request |
| host_done | output | 1 | One-cycle pulse when the message is finished |
| setup_valid | output | 1 | Setup packet valid on the control port |
| setup_dest | output | 6 | Destination carried by the setup packet |
| blocked_in | input | 1 | Path-blocked packet returned to this source |
| ack_in | input | 1 | Optical acknowledgment pulse received |
| data_valid | output | 1 | A data word is being modulated this cycle |
| data_idx | output | 9 | Index of the word the host must supply |
| teardown_out | output | 1 | Teardown pulse that releases the path |
| setup_in | input | 1 | Setup packet arrived for this node |
| ack_out | output | 1 | Acknowledgment pulse sent back to the source |
| rx_valid | input | 1 | Detected data word valid |
| rx_data | input | 32 | Detected data word |
| teardown_in | input | 1 | Teardown received from upstream |
| rx_out_valid | output | 1 | Received word valid toward the host |
| rx_out_data | output | 32 | Received word toward the host |

## Verification
The bench targets an acknowledgment that arrives one cycle early, while the setup packet is still on the port. A design that latched it would start streaming on an unreserved path. It drives acknowledgment and path-blocked in the same cycle; a design with the wrong priority would send data into a failed setup. The bench measures the backoff length against its own LFSR, so a design that is off by one or samples the wrong LFSR value gives the wrong retry cycle. It also checks the 511th word boundary, where a wrong count sends 511 or 513 words, and it checks that requests or setups arriving mid-circuit neither restart the sender nor answer a second source.

// File: rtl/path_pkg.sv
package path_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP_SENT,
        S_WAIT_ACK,
        S_TRANSMIT,
        S_TEARDOWN,
        S_BACKOFF
    } src_state_t;

    typedef enum logic {
        D_IDLE,
        D_RECEIVE
    } dst_state_t;
endpackage

// File: rtl/path_lfsr.sv
module path_lfsr #(
    parameter int          W     = 16,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1,
    parameter int          OUT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd
);
    logic [W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (!rst_n)          state_q <= SEED;
        else if (state_q[0]) state_q <= (state_q >> 1) ^ TAPS;
        else                 state_q <= state_q >> 1;
    end

    assign rnd = state_q[OUT_W-1:0];
endmodule

// File: rtl/path_src_fsm.sv
module path_src_fsm
    import path_pkg::*;
#(
    parameter int DEST_W         = 6,
    parameter int MSG_WORDS      = 512,
    parameter int BACKOFF_BASE   = 8,
    parameter int BACKOFF_SPAN_W = 4,
    localparam int IDX_W         = $clog2(MSG_WORDS),
    localparam int CNT_W         = $clog2(BACKOFF_BASE + (1 << BACKOFF_SPAN_W))
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      host_req,
    input  logic [DEST_W-1:0]         host_dest,
    input  logic                      blocked_in,
    input  logic                      ack_in,
    input  logic [BACKOFF_SPAN_W-1:0] rnd,
    output logic                      host_done,
    output logic                      setup_valid,
    output logic [DEST_W-1:0]         setup_dest,
    output logic                      data_valid,
    output logic [IDX_W-1:0]          data_idx,
    output logic                      teardown_out
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MSG_WORDS - 1);

    src_state_t          state_q, state_d;
    logic [IDX_W-1:0]    idx_q;
    logic [CNT_W-1:0]    wait_q;
    logic [DEST_W-1:0]   dest_q;
    logic                done_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:       if (host_req) state_d = S_SETUP_SENT;
            S_SETUP_SENT: state_d = S_WAIT_ACK;
            S_WAIT_ACK: begin
                if (blocked_in)  state_d = S_BACKOFF;
                else if (ack_in) state_d = S_TRANSMIT;
            end
            S_TRANSMIT:   if (idx_q == LAST_IDX) state_d = S_TEARDOWN;
            S_TEARDOWN:   state_d = S_IDLE;
            S_BACKOFF:    if (wait_q == '0) state_d = S_SETUP_SENT;
            default:      state_d = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            wait_q <= '0;
            dest_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q == S_TEARDOWN);
            if (state_q == S_IDLE && host_req) dest_q <= host_dest;
            if (state_q == S_TRANSMIT) idx_q <= idx_q + 1'b1;
            else                       idx_q <= '0;
            if (state_q == S_WAIT_ACK && blocked_in)
                wait_q <= CNT_W'(BACKOFF_BASE - 1) + CNT_W'(rnd);
            else if (state_q == S_BACKOFF && wait_q != '0)
                wait_q <= wait_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        setup_valid  = (state_q == S_SETUP_SENT);
        data_valid   = (state_q == S_TRANSMIT);
        teardown_out = (state_q == S_TEARDOWN);
        setup_dest   = dest_q;
        data_idx     = idx_q;
        host_done    = done_q;
    end
endmodule

// File: rtl/path_dst_fsm.sv
module path_dst_fsm
    import path_pkg::*;
#(
    parameter int WORD_BITS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 setup_in,
    input  logic                 rx_valid,
    input  logic [WORD_BITS-1:0] rx_data,
    input  logic                 teardown_in,
    output logic                 ack_out,
    output logic                 rx_out_valid,
    output logic [WORD_BITS-1:0] rx_out_data
);
    dst_state_t           state_q, state_d;
    logic                 ack_q, rxv_q;
    logic [WORD_BITS-1:0] rxd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= D_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            D_IDLE:    if (setup_in)    state_d = D_RECEIVE;
            D_RECEIVE: if (teardown_in) state_d = D_IDLE;
            default:   state_d = D_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            rxv_q <= 1'b0;
            rxd_q <= '0;
        end else begin
            ack_q <= (state_q == D_IDLE) && setup_in;
            rxv_q <= (state_q == D_RECEIVE) && rx_valid;
            if ((state_q == D_RECEIVE) && rx_valid) rxd_q <= rx_data;
        end
    end

    always_comb begin
        ack_out      = ack_q;
        rx_out_valid = rxv_q;
        rx_out_data  = rxd_q;
    end
endmodule

// File: rtl/path_setup_ni.sv
module path_setup_ni #(
    parameter int          DEST_W         = 6,
    parameter int          MSG_BYTES      = 2048,
    parameter int          WORD_BITS      = 32,
    parameter int          BACKOFF_BASE   = 8,
    parameter int          BACKOFF_SPAN_W = 4,
    parameter int          LFSR_W         = 16,
    parameter logic [15:0] LFSR_TAPS      = 16'hB400,
    parameter logic [15:0] LFSR_SEED      = 16'hACE1,
    localparam int         MSG_WORDS      = MSG_BYTES * 8 / WORD_BITS,
    localparam int         IDX_W          = $clog2(MSG_WORDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_req,
    input  logic [DEST_W-1:0]    host_dest,
    output logic                 host_done,
    output logic                 setup_valid,
    output logic [DEST_W-1:0]    setup_dest,
    input  logic                 blocked_in,
    input  logic                 ack_in,
    output logic                 data_valid,
    output logic [IDX_W-1:0]     data_idx,
    output logic                 teardown_out,
    input  logic                 setup_in,
    output logic                 ack_out,
    input  logic                 rx_valid,
    input  logic [WORD_BITS-1:0] rx_data,
    input  logic                 teardown_in,
    output logic                 rx_out_valid,
    output logic [WORD_BITS-1:0] rx_out_data
);
    logic [BACKOFF_SPAN_W-1:0] rnd;

    path_lfsr #(
        .W(LFSR_W), .TAPS(LFSR_TAPS[LFSR_W-1:0]),
        .SEED(LFSR_SEED[LFSR_W-1:0]), .OUT_W(BACKOFF_SPAN_W)
    ) u_lfsr (
        .clk(clk), .rst_n(rst_n), .rnd(rnd)
    );

    path_src_fsm #(
        .DEST_W(DEST_W), .MSG_WORDS(MSG_WORDS),
        .BACKOFF_BASE(BACKOFF_BASE), .BACKOFF_SPAN_W(BACKOFF_SPAN_W)
    ) u_src (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_dest(host_dest),
        .blocked_in(blocked_in), .ack_in(ack_in), .rnd(rnd),
        .host_done(host_done), .setup_valid(setup_valid),
        .setup_dest(setup_dest), .data_valid(data_valid),
        .data_idx(data_idx), .teardown_out(teardown_out)
    );

    path_dst_fsm #(
        .WORD_BITS(WORD_BITS)
    ) u_dst (
        .clk(clk), .rst_n(rst_n),
        .setup_in(setup_in), .rx_valid(rx_valid), .rx_data(rx_data),
        .teardown_in(teardown_in), .ack_out(ack_out),
        .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data)
    );
endmodule

// File: rtl/path_setup_ni_chk.sv
module path_setup_ni_chk #(
    parameter int MSG_WORDS = 512,
    parameter int IDX_W     = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack_in,
    input logic             blocked_in,
    input logic             setup_valid,
    input logic             data_valid,
    input logic [IDX_W-1:0] data_idx,
    input logic             teardown_out,
    input logic             host_done,
    input logic             ack_out,
    input logic             rx_valid,
    input logic             rx_out_valid
);
    AST_DATA_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_valid) |-> ($past(ack_in) && !$past(blocked_in))); // R3
    AST_SETUP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        setup_valid |=> !setup_valid); // R2
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && $past(data_valid)) |-> (data_idx == $past(data_idx) + 1'b1)); // R4
    AST_TD_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && data_idx == IDX_W'(MSG_WORDS - 1)) |=> (teardown_out && !data_valid)); // R5
    AST_DONE_AFTER_TD: assert property (@(posedge clk) disable iff (!rst_n)
        teardown_out |=> host_done); // R5
    AST_NO_DATA_ON_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked_in && !data_valid) |=> !data_valid); // R6
    AST_ACK_OUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_out |=> !ack_out); // R9
    AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_out_valid |-> $past(rx_valid)); // R10
endmodule

bind path_setup_ni path_setup_ni_chk #(.MSG_WORDS(MSG_WORDS), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ack_in(ack_in), .blocked_in(blocked_in),
    .setup_valid(setup_valid), .data_valid(data_valid), .data_idx(data_idx),
    .teardown_out(teardown_out), .host_done(host_done), .ack_out(ack_out),
    .rx_valid(rx_valid), .rx_out_valid(rx_out_valid)
);

// File: tb/path_setup_ni_tb.sv
module path_setup_ni_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic [5:0]  host_dest = '0;
    logic        host_done, setup_valid, data_valid, teardown_out, ack_out, rx_out_valid;
    logic [5:0]  setup_dest;
    logic        blocked_in = 1'b0, ack_in = 1'b0;
    logic [8:0]  data_idx;
    logic        setup_in = 1'b0, rx_valid = 1'b0, teardown_in = 1'b0;
    logic [31:0] rx_data = '0, rx_out_data;

    int checks = 0, failures = 0, cyc = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    path_setup_ni u_dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_dest(host_dest),
        .host_done(host_done), .setup_valid(setup_valid), .setup_dest(setup_dest),
        .blocked_in(blocked_in), .ack_in(ack_in), .data_valid(data_valid),
        .data_idx(data_idx), .teardown_out(teardown_out), .setup_in(setup_in),
        .ack_out(ack_out), .rx_valid(rx_valid), .rx_data(rx_data),
        .teardown_in(teardown_in), .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    function automatic logic [15:0] lfsr_next(input logic [15:0] s);
        return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
    endfunction

    int          m_src;      // 0 idle 1 setup 2 wait 3 send 4 teardown 5 backoff
    int          m_idx, m_wait;
    bit          m_done, m_rcv, m_ack, m_rxv;
    logic [5:0]  m_dest;
    logic [31:0] m_rxd;
    logic [15:0] m_lfsr;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_src <= 0; m_idx <= 0; m_wait <= 0; m_done <= 0; m_dest <= '0;
            m_rcv <= 0; m_ack <= 0; m_rxv <= 0; m_rxd <= '0; m_lfsr <= 16'hACE1;
        end else begin
            m_lfsr <= lfsr_next(m_lfsr);
            m_done <= (m_src == 4);
            case (m_src)
                0: if (host_req) begin m_src <= 1; m_dest <= host_dest; end
                1: m_src <= 2;
                2: if (blocked_in) begin m_src <= 5; m_wait <= 7 + int'(m_lfsr[3:0]); end
                   else if (ack_in) begin m_src <= 3; m_idx <= 0; end
                3: if (m_idx == 511) m_src <= 4; else m_idx <= m_idx + 1;
                4: m_src <= 0;
                5: if (m_wait == 0) m_src <= 1; else m_wait <= m_wait - 1;
                default: m_src <= 0;
            endcase
            m_ack <= !m_rcv && setup_in;
            m_rxv <= m_rcv && rx_valid;
            if (m_rcv && rx_valid) m_rxd <= rx_data;
            if (!m_rcv && setup_in) m_rcv <= 1;
            else if (m_rcv && teardown_in) m_rcv <= 0;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(setup_valid == (m_src == 1), "R2 setup_valid", setup_valid, m_src == 1);
            if (setup_valid) chk(setup_dest == m_dest, "R2 setup_dest", setup_dest, m_dest);
            chk(data_valid == (m_src == 3), "R3 data_valid", data_valid, m_src == 3);
            if (data_valid) chk(data_idx == m_idx, "R4 data_idx", data_idx, m_idx);
            chk(teardown_out == (m_src == 4), "R5 teardown_out", teardown_out, m_src == 4);
            chk(host_done == m_done, "R5 host_done", host_done, m_done);
            chk(ack_out == m_ack, "R9 ack_out", ack_out, m_ack);
            chk(rx_out_valid == m_rxv, "R10 rx_out_valid", rx_out_valid, m_rxv);
            if (rx_out_valid) chk(rx_out_data == m_rxd, "R10 rx_out_data", rx_out_data, m_rxd);
        end
        if (cyc > WATCHDOG && !finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic request(input logic [5:0] d);
        @(negedge clk);
        host_req = 1'b1; host_dest = d;
        do @(negedge clk); while (!setup_valid);
        host_req = 1'b0;
    endtask

    task automatic ack_and_finish(output int words);
        @(negedge clk); ack_in = 1'b1;
        @(negedge clk); ack_in = 1'b0;
        words = 0;
        while (!host_done) begin
            if (data_valid) words++;
            @(negedge clk);
        end
    endtask

    initial begin
        int words, gap, r;
        bit seen;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({setup_valid, data_valid, teardown_out, host_done, ack_out, rx_out_valid} == 6'b0,
            "R1 outputs in reset",
            {setup_valid, data_valid, teardown_out, host_done, ack_out, rx_out_valid}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R4 R5: plain message
        request(6'd5);
        chk(setup_dest == 6'd5, "R2 dest carried", setup_dest, 5);
        ack_and_finish(words);
        chk(words == 512, "R4 word count", words, 512);
        @(negedge clk);
        chk(!host_done && !teardown_out, "R5 done single pulse", host_done, 0);

        // R7: ack while idle has no effect
        ack_in = 1'b1; @(negedge clk); ack_in = 1'b0;
        repeat (3) begin @(negedge clk); chk(!data_valid, "R7 ack in idle", data_valid, 0); end

        // R7: ack during SETUP_SENT is ignored
        @(negedge clk); host_req = 1'b1; host_dest = 6'd9;
        do @(negedge clk); while (!setup_valid);
        host_req = 1'b0; ack_in = 1'b1;
        @(negedge clk); ack_in = 1'b0;
        repeat (4) begin @(negedge clk); chk(!data_valid, "R7 early ack ignored", data_valid, 0); end
        @(negedge clk); ack_in = 1'b1; @(negedge clk); ack_in = 1'b0;
        words = 0;
        while (!host_done) begin if (data_valid) words++; @(negedge clk); end
        chk(words == 512, "R3 data after real ack", words, 512);

        // R6: path blocked and backoff
        for (int k = 0; k < 3; k++) begin
            request(6'(k + 20));
            @(negedge clk);
            blocked_in = 1'b1; r = int'(m_lfsr[3:0]);
            gap = 0; seen = 0;
            do begin
                @(negedge clk); blocked_in = 1'b0; gap++;
                if (data_valid) seen = 1;
            end while (!setup_valid && gap < 100);
            chk(gap == 9 + r, "R6 backoff length", gap, 9 + r);
            chk(!seen, "R6 no data when blocked", seen, 0);
            chk(setup_dest == 6'(k + 20), "R6 retry same dest", setup_dest, k + 20);
            ack_and_finish(words);
            chk(words == 512, "R6 message after retry", words, 512);
        end

        // R8: ack and blocked together
        request(6'd33);
        @(negedge clk); ack_in = 1'b1; blocked_in = 1'b1;
        @(negedge clk); ack_in = 1'b0; blocked_in = 1'b0;
        chk(!data_valid, "R8 blocked wins", data_valid, 0);
        do @(negedge clk); while (!setup_valid);
        ack_and_finish(words);
        chk(words == 512, "R8 message after retry", words, 512);

        // R11: host_req while transmitting
        request(6'd40);
        @(negedge clk); ack_in = 1'b1; @(negedge clk); ack_in = 1'b0;
        host_req = 1'b1; host_dest = 6'd41; seen = 0;
        repeat (100) begin @(negedge clk); if (setup_valid) seen = 1; end
        host_req = 1'b0;
        chk(!seen, "R11 request while busy", seen, 0);
        while (!host_done) @(negedge clk);
        @(negedge clk);
        chk(!setup_valid, "R11 no late setup", setup_valid, 0);

        // R9 R10: destination side
        rx_valid = 1'b1; rx_data = 32'hDEAD0001;
        @(negedge clk); rx_valid = 1'b0;
        @(negedge clk);
        chk(!rx_out_valid, "R10 rx outside circuit dropped", rx_out_valid, 0);
        setup_in = 1'b1; @(negedge clk); setup_in = 1'b0;
        chk(ack_out, "R9 ack on setup", ack_out, 1);
        for (int i = 0; i < 20; i++) begin
            rx_valid = (i % 3) != 1; rx_data = 32'h1000_0000 + 32'(i * 7);
            if (i == 5) setup_in = 1'b1;
            @(negedge clk);
            setup_in = 1'b0;
            if (i == 5) chk(!ack_out, "R9 no ack while receiving", ack_out, 0);
        end
        rx_valid = 1'b0; teardown_in = 1'b1;
        @(negedge clk); teardown_in = 1'b0;
        rx_valid = 1'b1; rx_data = 32'h55;
        @(negedge clk); rx_valid = 1'b0;
        @(negedge clk);
        chk(!rx_out_valid, "R10 dropped after teardown", rx_out_valid, 0);
        repeat (3) @(negedge clk);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule